// File: doc/BRIEF.md
# Two-Way Translation Cache Set

This block is a single set of a two-way translation cache that sits in front of a page-table walker. Each of its two ways remembers one page translation: the virtual page it covers, the second word of the page-table entry that produced it (from which the physical page number is taken), a valid flag and a most-recently-used flag. A requester presents a virtual address together with an access kind and receives, one clock later, either a hit with the full physical address or a miss. After a walk completes, the walker installs the new translation through a separate fill port.

The set tracks which way was touched last. A fill evicts the other way. A write to a page whose cached entry still shows the page as unmodified is turned into a miss. At the same time the modified bit is set in the cached copy, so that the walker can record the modification in memory. Probe accesses translate without disturbing any state, and fills tagged as probes are dropped.

Top module: `tlb2_set`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` is 0. Reset clears every way to invalid, so every lookup after reset misses until a fill is made.
- R2: A lookup presented with `lk_valid` high yields `rsp_valid` high on the next clock. On a hit, `rsp_hit` is 1 and `rsp_paddr` = {entry bits 31:12, lookup address bits 11:0}. On a miss, `rsp_hit` is 0 and `rsp_paddr` is 0. Access kinds are encoded as 00 read, 01 write, 10 fetch and 11 probe.
- R3: A way matches only when it is valid and its stored page equals lookup address bits 31:12. An address on any other page misses.
- R4: A fill stores fill address bits 31:12 as the page. The fill address bits 11:0 are ignored. The physical page is taken from entry bits 31:12.
- R5: A fill writes way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way not marked most recent. The written way becomes most recent and the other way's mark is cleared.
- R6: A read, fetch or translating write hit marks the hitting way most recent.
- R7: A probe lookup that hits returns the translation but leaves the most-recent marks unchanged.
- R8: A write lookup that hits an entry whose modified bit (entry bit 7) is 0 responds as a miss, sets that bit in the cached entry, and leaves the most-recent marks unchanged. The next write to the same page hits.
- R9: A fill whose access kind is probe (11) leaves the set unchanged.
- R10: If both ways hold the same page, way 0's translation is returned.
- R11: Read and fetch hits translate regardless of the modified bit and do not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_kind | input | 2 | Lookup access kind |
| fill_valid | input | 1 | Fill request strobe |
| fill_vaddr | input | 32 | Virtual address of the new translation |
| fill_pte | input | 32 | Second page-table-entry word to cache |
| fill_kind | input | 2 | Access kind that caused the walk |
| rsp_valid | output | 1 | Response strobe, one cycle after a lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 32 | Physical address on a hit, zero on a miss |

## Verification
The replacement state cannot be seen at the ports, which makes it the hardest thing to reach. It can be observed only through which translation a later fill evicts. Each scenario fills both ways, applies the access under test (a read hit, a probe hit or a write that hits an unmodified entry), and then forces an eviction with a third fill. Lookups of the survivors then reveal whether the most-recent mark moved.

// File: rtl/tlb2_pkg.sv
package tlb2_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_PROBE = 2'b11
  } acc_e;
endpackage

// File: rtl/tlb2_way.sv
// One way of the set: valid, most-recent mark, page tag and cached entry word.
module tlb2_way #(
  parameter int TAG_W = 20,
  parameter int PTE_W = 32,
  parameter int C_BIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic             mru_set,
  input  logic             mru_clr,
  input  logic             c_set,
  output logic             vld,
  output logic             mru,
  output logic [TAG_W-1:0] tag,
  output logic [PTE_W-1:0] pte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      mru <= 1'b0;
      tag <= '0;
      pte <= '0;
    end else begin
      if (fill_en) begin
        vld <= 1'b1;
        tag <= fill_tag;
        pte <= fill_pte;
      end else if (c_set) begin
        pte[C_BIT] <= 1'b1;
      end
      if (mru_set)      mru <= 1'b1;
      else if (mru_clr) mru <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb2_victim.sv
// Replacement choice: first invalid way, else the way not marked most recent.
module tlb2_victim (
  input  logic [1:0] vld,
  input  logic [1:0] mru,
  output logic       victim
);
  always_comb begin
    if (!vld[0])      victim = 1'b0;
    else if (!vld[1]) victim = 1'b1;
    else              victim = mru[0];
  end
endmodule

// File: rtl/tlb2_set.sv
module tlb2_set
  import tlb2_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int C_BIT      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  input  logic             fill_valid,
  input  logic [VA_W-1:0]  fill_vaddr,
  input  logic [PTE_W-1:0] fill_pte,
  input  logic [1:0]       fill_kind,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PTE_W-1:0] rsp_paddr
);
  localparam int TAG_W = VA_W - PAGE_SHIFT;
  localparam int NWAY  = 2;

  acc_e lk_acc, fill_acc;
  assign lk_acc   = acc_e'(lk_kind);
  assign fill_acc = acc_e'(fill_kind);

  logic [TAG_W-1:0] lk_tag;
  assign lk_tag = lk_vaddr[VA_W-1:PAGE_SHIFT];

  logic [NWAY-1:0]  vld, mru, match, fill_en, mru_set, mru_clr, c_set;
  logic [TAG_W-1:0] tag [NWAY];
  logic [PTE_W-1:0] pte [NWAY];

  logic             victim, hit_way, hit_any, need_c, good, touch, fill_go;
  logic [PTE_W-1:0] hit_pte;

  tlb2_victim u_victim (.vld(vld), .mru(mru), .victim(victim));

  // Lookup decode; way 0 wins when both ways match (R10)
  always_comb begin
    hit_any = |match;
    hit_way = match[0] ? 1'b0 : 1'b1;
    hit_pte = pte[hit_way];
    need_c  = (lk_acc == ACC_WRITE) && !hit_pte[C_BIT];
    good    = lk_valid && hit_any && !need_c;
    touch   = good && (lk_acc != ACC_PROBE);
    fill_go = fill_valid && (fill_acc != ACC_PROBE);
  end

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    assign match[w]   = vld[w] && (tag[w] == lk_tag);
    assign fill_en[w] = fill_go && (victim == 1'(w));
    assign mru_set[w] = fill_go ? (victim == 1'(w))  : (touch && hit_way == 1'(w));
    assign mru_clr[w] = fill_go ? (victim != 1'(w))  : (touch && hit_way != 1'(w));
    assign c_set[w]   = lk_valid && hit_any && need_c && (hit_way == 1'(w));

    tlb2_way #(.TAG_W(TAG_W), .PTE_W(PTE_W), .C_BIT(C_BIT)) u_way (
      .clk     (clk),
      .rst     (rst),
      .fill_en (fill_en[w]),
      .fill_tag(fill_vaddr[VA_W-1:PAGE_SHIFT]),
      .fill_pte(fill_pte),
      .mru_set (mru_set[w]),
      .mru_clr (mru_clr[w]),
      .c_set   (c_set[w]),
      .vld     (vld[w]),
      .mru     (mru[w]),
      .tag     (tag[w]),
      .pte     (pte[w])
    );
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= good;
      rsp_paddr <= good ? {hit_pte[PTE_W-1:PAGE_SHIFT], lk_vaddr[PAGE_SHIFT-1:0]} : '0;
    end
  end

  // R5: at most one way carries the most-recent mark
  a_r5_mru_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(mru));
  // R5: the filled way is valid and most recent afterwards
  a_r5_fill_mru: assert property (@(posedge clk) disable iff (rst)
    fill_go |=> (vld[$past(victim)] && mru[$past(victim)]));
  // R8: a write to an unmodified cached entry answers miss and marks the copy
  a_r8_c_miss: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !fill_valid && lk_acc == ACC_WRITE && hit_any && !hit_pte[C_BIT])
    |=> (!rsp_hit && pte[$past(hit_way)][C_BIT]));
  // R9: a probe-kind fill changes nothing
  a_r9_probe_fill: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_acc == ACC_PROBE && !lk_valid) |=> ($stable(vld) && $stable(mru)));
  // R7: a probe lookup leaves the replacement marks alone
  a_r7_probe_mru: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_acc == ACC_PROBE && !fill_valid) |=> $stable(mru));
  // R2: a miss returns a zero address
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));
endmodule

// File: tb/tlb2_set_test.sv
`timescale 1ns/1ps
module tlb2_set_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_vaddr = '0;
  logic [31:0] fill_pte = '0;
  logic [1:0]  fill_kind = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr;

  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_IF = 2'b10, K_PR = 2'b11;
  localparam logic [31:0] VA_A = 32'h1000_0ABC, VA_B = 32'h2000_0123, VA_C = 32'h3000_0FFF;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tlb2_set uut (.*);

  function automatic logic [31:0] mk_pte(input logic [19:0] rpn, input logic c);
    return {rpn, 12'h000} | (c ? 32'h80 : 32'h0);
  endfunction

  task automatic chk(input string req, input logic hit, input logic exp_hit,
                     input logic [31:0] pa, input logic [31:0] exp_pa);
    checks++;
    if (hit !== exp_hit || pa !== exp_pa) begin
      fails++;
      $display("FAIL %s: hit=%0b pa=%h expected hit=%0b pa=%h", req, hit, pa, exp_hit, exp_pa);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] p, input logic [1:0] k);
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = va; fill_pte = p; fill_kind = k;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic [1:0] k,
                      input logic exp_hit, input logic [31:0] exp_pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = k;
    @(negedge clk);
    lk_valid = 1'b0;
    checks++;
    if (rsp_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: rsp_valid=%0b expected 1", req, rsp_valid);
    end
    chk(req, rsp_hit, exp_hit, rsp_paddr, exp_pa);
  endtask

  task automatic t_reset();
    do_reset();
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid=%0b expected 0", rsp_valid);
    end
    look("R1 empty after reset", 32'h0000_1234, K_RD, 1'b0, 32'h0);
  endtask

  task automatic t_basic();
    do_reset();
    fill(32'h1234_5ABC, mk_pte(20'hABCDE, 1'b1), K_RD);
    look("R4 R2 read hit", 32'h1234_5123, K_RD, 1'b1, 32'hABCD_E123);
    look("R11 fetch hit", 32'h1234_5FFF, K_IF, 1'b1, 32'hABCD_EFFF);
    look("R3 other page", 32'h1234_6123, K_RD, 1'b0, 32'h0);
  endtask

  task automatic t_mru_hit();
    do_reset();
    fill(VA_A, mk_pte(20'h0000A, 1'b1), K_RD);
    fill(VA_B, mk_pte(20'h0000B, 1'b1), K_RD);
    look("R6 read A", VA_A, K_RD, 1'b1, 32'h0000_AABC);
    fill(VA_C, mk_pte(20'h0000C, 1'b1), K_RD);
    look("R6 B evicted", VA_B, K_RD, 1'b0, 32'h0);
    look("R6 A kept", VA_A, K_RD, 1'b1, 32'h0000_AABC);
    look("R5 C present", VA_C, K_RD, 1'b1, 32'h0000_CFFF);
  endtask

  task automatic t_lru_fill();
    do_reset();
    fill(VA_A, mk_pte(20'h0000A, 1'b1), K_WR);
    fill(VA_B, mk_pte(20'h0000B, 1'b1), K_IF);
    fill(VA_C, mk_pte(20'h0000C, 1'b1), K_RD);
    look("R5 A evicted", VA_A, K_RD, 1'b0, 32'h0);
    look("R5 B kept", VA_B, K_RD, 1'b1, 32'h0000_B123);
  endtask

  task automatic t_probe();
    do_reset();
    fill(VA_A, mk_pte(20'h0000A, 1'b1), K_RD);
    fill(VA_B, mk_pte(20'h0000B, 1'b1), K_RD);
    look("R7 probe hit", VA_A, K_PR, 1'b1, 32'h0000_AABC);
    fill(VA_C, mk_pte(20'h0000C, 1'b1), K_RD);
    look("R7 A evicted after probe", VA_A, K_RD, 1'b0, 32'h0);
    look("R7 B kept", VA_B, K_RD, 1'b1, 32'h0000_B123);
  endtask

  task automatic t_cbit();
    do_reset();
    fill(VA_A, mk_pte(20'h0000A, 1'b0), K_RD);
    look("R11 read unmodified", VA_A, K_RD, 1'b1, 32'h0000_AABC);
    look("R11 fetch unmodified", VA_A, K_IF, 1'b1, 32'h0000_AABC);
    look("R8 first write misses", VA_A, K_WR, 1'b0, 32'h0);
    look("R8 second write hits", VA_A, K_WR, 1'b1, 32'h0000_AABC);
    do_reset();
    fill(VA_A, mk_pte(20'h0000A, 1'b0), K_RD);
    fill(VA_B, mk_pte(20'h0000B, 1'b1), K_RD);
    look("R8 write miss", VA_A, K_WR, 1'b0, 32'h0);
    fill(VA_C, mk_pte(20'h0000C, 1'b1), K_RD);
    look("R8 mark unchanged, A evicted", VA_A, K_RD, 1'b0, 32'h0);
  endtask

  task automatic t_probe_fill();
    do_reset();
    fill(VA_A, mk_pte(20'h0000A, 1'b1), K_RD);
    fill(VA_B, mk_pte(20'h0000B, 1'b1), K_RD);
    fill(VA_C, mk_pte(20'h0000C, 1'b1), K_PR);
    look("R9 C absent", VA_C, K_RD, 1'b0, 32'h0);
    look("R9 A kept", VA_A, K_RD, 1'b1, 32'h0000_AABC);
    look("R9 B kept", VA_B, K_RD, 1'b1, 32'h0000_B123);
  endtask

  task automatic t_dup();
    do_reset();
    fill(VA_A, mk_pte(20'h11111, 1'b1), K_RD);
    fill(VA_A, mk_pte(20'h22222, 1'b1), K_RD);
    look("R10 way 0 wins", VA_A, K_RD, 1'b1, 32'h1111_1ABC);
  endtask

  task automatic t_reset_mid();
    do_reset();
    fill(VA_A, mk_pte(20'h0000A, 1'b1), K_RD);
    look("R1 before reset", VA_A, K_RD, 1'b1, 32'h0000_AABC);
    do_reset();
    look("R1 cleared by reset", VA_A, K_RD, 1'b0, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_mru_hit();
    t_lru_fill();
    t_probe();
    t_cbit();
    t_probe_fill();
    t_dup();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule